// File: doc/BRIEF.md
# Condition Code and Branch Resolver

This block keeps the three processor condition flags (negative, zero, positive) and works out where the program counter goes next. Each cycle it watches the value being written back to the register file. When the write strobe and the "this opcode sets the codes" flag are both high, it classifies that value and stores the result as the new flag set. Exactly one flag is ever active.

In parallel, the block decodes the current instruction word. A conditional branch ANDs its three mask bits with the stored flags and is taken if any masked flag is set. An indirect jump takes its target from a register value, and the return form of that jump uses register 7. The block drives the resulting next PC, a taken indication and the current flags. The caller supplies the register file values and the post-fetch PC through input ports. The block has no storage of its own apart from the three flag bits.

Top module: `flow_resolver`

## Requirements
- R1: After reset the flags output is 3'b010, with bit 2 = N, bit 1 = Z and bit 0 = P. Exactly one of the three bits is 1 at all times.
- R2: On a clock edge where `wr_en` and `cc_upd` are both 1, the flags become 3'b100 if `wr_data[15]` is 1, 3'b010 if `wr_data` is zero, and 3'b001 otherwise.
- R3: On an edge where `wr_en` or `cc_upd` is 0, the flags keep their value.
- R4: A conditional branch has `instr[15:12]`=4'b0000 and mask bits n, z, p in `instr[11]`, `instr[10]` and `instr[9]`. It is taken when (n&N)|(z&Z)|(p&P) is true. Mask 000 is never taken and mask 111 is always taken.
- R5: The target of a taken branch is `pc_in` plus `instr[8:0]` sign-extended to 16 bits, with wraparound.
- R6: An indirect jump has `instr[15:12]`=4'b1100, `instr[11:9]`=0 and `instr[5:0]`=0, and a base field in `instr[8:6]` other than 7. It is always taken and its target is `base_val`.
- R7: The 4'b1100 encoding with base field 7 (word 16'hC1C0) is a return. It is taken and its target is `r7_val`, whatever `base_val` holds.
- R8: When nothing is taken, `taken` is 0 and `next_pc` equals `pc_in`. This covers a false branch condition, any other opcode, a 4'b1100 word with a nonzero reserved field, and `instr_valid` = 0.
- R9: If a flag update and a branch occur in the same cycle, the branch uses the flags from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A register write-back happens this cycle |
| cc_upd | input | 1 | The writing opcode updates the condition codes |
| wr_data | input | 16 | Value being written back |
| instr_valid | input | 1 | `instr` holds a live instruction |
| instr | input | 16 | Decoded instruction word |
| pc_in | input | 16 | Post-fetch program counter |
| base_val | input | 16 | Value of the register named by `instr[8:6]` |
| r7_val | input | 16 | Value of register 7 |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | A redirect is happening |
| flags | output | 3 | Current {N,Z,P} |

## Verification
The hardest case to reach is the one where a flag update and a branch evaluation happen in the same cycle. Here the flags the branch reads are about to be overwritten. The bench sets the flags to negative, then in one cycle presents a negative-only branch together with a write of zero. It samples `taken` before the edge and again after it, which shows the old flags deciding the branch and the new ones taking effect only on the following cycle. A return is also presented with `base_val` and `r7_val` holding different values, so choosing the wrong source changes `next_pc`.

// File: rtl/flow_resolver.sv
module flow_resolver #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cc_upd,
  input  logic [DW-1:0] wr_data,
  input  logic          instr_valid,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] r7_val,
  output logic [DW-1:0] next_pc,
  output logic          taken,
  output logic [2:0]    flags
);
  localparam int OFFW = 9;
  localparam logic [3:0] OP_BR  = 4'b0000;
  localparam logic [3:0] OP_JMP = 4'b1100;

  logic [2:0] cc_q, cc_d;
  logic [3:0] opc;
  logic [DW-1:0] br_tgt, jmp_tgt;
  logic br_hit, jmp_hit;

  assign cc_d = wr_data[DW-1]      ? 3'b100 :
                (wr_data == '0)    ? 3'b010 : 3'b001;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cc_q <= 3'b010;
    else if (wr_en && cc_upd)  cc_q <= cc_d;

  assign opc     = instr[15:12];
  assign br_hit  = instr_valid && opc == OP_BR && |(instr[11:9] & cc_q);
  assign jmp_hit = instr_valid && opc == OP_JMP &&
                   instr[11:9] == 3'b000 && instr[5:0] == 6'b000000;
  assign br_tgt  = pc_in + {{(DW-OFFW){instr[OFFW-1]}}, instr[OFFW-1:0]};
  assign jmp_tgt = (instr[8:6] == 3'd7) ? r7_val : base_val;

  assign taken   = br_hit | jmp_hit;
  assign next_pc = jmp_hit ? jmp_tgt : br_hit ? br_tgt : pc_in;
  assign flags   = cc_q;
endmodule

module flow_resolver_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          cc_upd,
  input logic [DW-1:0] wr_data,
  input logic          instr_valid,
  input logic [15:0]   instr,
  input logic [DW-1:0] pc_in,
  input logic [DW-1:0] base_val,
  input logic [DW-1:0] r7_val,
  input logic [DW-1:0] next_pc,
  input logic          taken,
  input logic [2:0]    flags
);
  a_r1_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);
  a_r2_zero_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cc_upd && wr_data == '0) |=> flags == 3'b010);
  a_r2_neg_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cc_upd && wr_data[DW-1]) |=> flags == 3'b100);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cc_upd) |=> $stable(flags));
  a_r4_mask_none: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] == 4'b0000 && instr[11:9] == 3'b000) |-> !taken);
  a_r4_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[15:12] == 4'b0000 && instr[11:9] == 3'b111) |-> taken);
  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr == 16'hC1C0) |-> (taken && next_pc == r7_val));
  a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> next_pc == pc_in);
  a_r8_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !taken);
endmodule

bind flow_resolver flow_resolver_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_flow_resolver.sv
module sim_flow_resolver;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, cc_upd = 0, instr_valid = 0;
  logic [15:0] wr_data = 0, instr = 0, pc_in = 16'h3004;
  logic [15:0] base_val = 16'h4321, r7_val = 16'h7777;
  logic [15:0] next_pc;
  logic taken;
  logic [2:0] flags;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flow_resolver u0 (.*);

  // {set value, instr, exp taken, exp next_pc}
  localparam logic [48:0] VEC [12] = '{
    {16'h0005, 16'h0209, 1'b1, 16'h300D},  // BRp +9 on P
    {16'h0000, 16'h0209, 1'b0, 16'h3004},  // BRp on Z
    {16'h8000, 16'h0DFF, 1'b1, 16'h3003},  // BRnz -1 on N
    {16'h8000, 16'h0005, 1'b0, 16'h3004},  // mask 000
    {16'h0000, 16'h0F00, 1'b1, 16'h2F04},  // mask 111, -256
    {16'h0000, 16'h0402, 1'b1, 16'h3006},  // BRz
    {16'h0000, 16'h0A02, 1'b0, 16'h3004},  // BRnp on Z
    {16'h0001, 16'hC080, 1'b1, 16'h4321},  // JMP R2
    {16'h0001, 16'hC1C0, 1'b1, 16'h7777},  // RET
    {16'h0001, 16'hC081, 1'b0, 16'h3004},  // reserved bits set
    {16'h0001, 16'h1000, 1'b0, 16'h3004},  // other opcode
    {16'hFFFF, 16'h08FF, 1'b1, 16'h3103}   // BRn +255
  };

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_val(input logic [15:0] v, input logic upd);
    @(negedge clk); wr_en = 1; cc_upd = upd; wr_data = v;
    @(negedge clk); wr_en = 0; cc_upd = 0;
  endtask

  function automatic logic [2:0] cls(input logic [15:0] v);
    return v[15] ? 3'b100 : (v == 0) ? 3'b010 : 3'b001;
  endfunction

  initial begin
    #4_000;
    @(negedge clk); rst_n = 1;
    #1 chk("R1 reset flags", flags, 3'b010);
    chk("R8 idle taken", taken, 0);
    chk("R8 idle next", next_pc, 16'h3004);

    foreach (VEC[i]) begin
      write_val(VEC[i][48:33], 1);
      chk("R2 classify", flags, cls(VEC[i][48:33]));
      instr = VEC[i][32:17]; instr_valid = 1;
      #1;
      chk("R4 R6 R7 R8 taken", taken, VEC[i][16]);
      chk("R5 R6 R7 R8 next_pc", next_pc, VEC[i][15:0]);
      @(negedge clk); instr_valid = 0;
    end

    // valid low suppresses
    write_val(16'h0000, 1);
    instr = 16'h0F05; instr_valid = 0; #1;
    chk("R8 invalid taken", taken, 0);
    chk("R8 invalid next", next_pc, 16'h3004);

    // R3: no update without both strobes
    write_val(16'h0042, 1);
    write_val(16'h0000, 0);
    chk("R3 cc_upd low", flags, 3'b001);
    @(negedge clk); wr_en = 0; cc_upd = 1; wr_data = 16'h8000;
    @(negedge clk); cc_upd = 0;
    chk("R3 wr_en low", flags, 3'b001);

    // R9: same cycle update and branch
    write_val(16'h8001, 1);
    @(negedge clk);
    instr = 16'h0810; instr_valid = 1;
    wr_en = 1; cc_upd = 1; wr_data = 16'h0000;
    #1 chk("R9 old flags taken", taken, 1);
    chk("R9 old flags next", next_pc, 16'h3014);
    @(negedge clk); wr_en = 0; cc_upd = 0;
    #1 chk("R9 new flags", flags, 3'b010);
    chk("R9 new taken", taken, 0);
    instr_valid = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule